// File: doc/BRIEF.md
# Reset Cause Recorder and Reset Release Sequencer

This block sits beside the reset logic of a small processor system. It watches single-cycle strobes that report why the system was reset: power-on, brown-out, the external reset pin, a reset instruction, a watchdog timeout, a trap conflict and an illegal opcode. It also watches strobes for entry into sleep or idle. Each cause is kept as a flag in a 16-bit status word. Software can overwrite that word. Hardware events on a flag override the software write.

On every reset-type event the block does three things. It picks the 3-bit clock-source code to use after the reset. It asserts the system reset and holds it through a power-on delay followed by a power-up timer delay. A new reset event during that count starts the sequence again. Oscillator start-up and PLL lock run in parallel with this count. Code may run only when the system reset has been released and both oscillator-ready and PLL-locked are high. A fixed number of cycles after release, the block enables the clock-fail monitor.

Top module: `reset_status_ctrl`

## Requirements
- R1: In `status`, bit 15 is the trap-conflict flag, bit 14 illegal opcode, bit 7 external pin, bit 6 reset instruction, bit 4 watchdog, bit 3 sleep, bit 2 idle, bit 1 brown-out and bit 0 power-on. Every other bit reads 0, so a software write of 0xFFFF reads back as 0xC0DF.
- R2: A power-on strobe sets bits 0 and 1. A brown-out strobe sets bit 1 only.
- R3: A power-on or brown-out strobe clears bits 15, 14, 6, 3 and 2. Bit 7 is cleared only by power-on. Bits 0 and 1 are never cleared by hardware. Flags can change only in the cycle after the strobe.
- R4: A sleep strobe sets bit 3 and an idle strobe sets bit 2. Either strobe clears bit 4, and so does a power-on or a brown-out strobe.
- R5: When `sw_wr_en` is high, the implemented bits take `sw_wr_data` on the next edge. On any bit, a hardware set in the same cycle beats a hardware clear, and a hardware clear beats the software write.
- R6: With `clk_switch_en` high, a power-on or brown-out strobe loads `clk_src_sel` from `cfg_osc_sel`. Any other reset strobe loads it from `cur_osc_sel`. If both kinds arrive in the same cycle, `cfg_osc_sel` wins.
- R7: With `clk_switch_en` low, every reset strobe loads `clk_src_sel` from `cfg_osc_sel`.
- R8: Any reset strobe (power-on, brown-out, pin, instruction, watchdog, trap, illegal opcode) makes `sys_rst` high from the next cycle. It stays high for exactly POR_CYC+PWRT_CYC cycles after the last such strobe.
- R9: `run_enable` is high exactly when `sys_rst` is low and both `osc_ready` and `pll_locked` are high.
- R10: `clkmon_en` rises once `sys_rst` has been low for MON_DLY cycles. It is low whenever `sys_rst` is high.
- R11: While `rst_n` is low, `status` is 0, `clk_src_sel` is 0, `sys_rst` is 1 and `clkmon_en` is 0. After `rst_n` rises, the delay sequence starts as if a reset strobe had arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset of the block |
| ev_por | input | 1 | Power-on strobe |
| ev_bor | input | 1 | Brown-out strobe |
| ev_pin | input | 1 | External pin reset strobe |
| ev_swrst | input | 1 | Reset instruction strobe |
| ev_wdt | input | 1 | Watchdog timeout strobe |
| ev_trap | input | 1 | Trap conflict strobe |
| ev_illop | input | 1 | Illegal opcode strobe |
| ev_sleep | input | 1 | Sleep entry strobe |
| ev_idle | input | 1 | Idle entry strobe |
| sw_wr_en | input | 1 | Software write enable for the status word |
| sw_wr_data | input | 16 | Software write data |
| clk_switch_en | input | 1 | Clock switching enabled |
| cfg_osc_sel | input | 3 | Configured oscillator code |
| cur_osc_sel | input | 3 | Current oscillator code |
| osc_ready | input | 1 | Oscillator start-up done |
| pll_locked | input | 1 | PLL lock done |
| status | output | 16 | Reset cause status word |
| clk_src_sel | output | 3 | Clock-source code chosen at the last reset |
| sys_rst | output | 1 | System reset, active high |
| run_enable | output | 1 | Code execution allowed |
| clkmon_en | output | 1 | Clock-fail monitor enable |

## Verification
The properties assume that the event inputs are clean single-cycle strobes sampled on the clock. They also assume that `cfg_osc_sel` and `cur_osc_sel` are stable at the edge where a reset strobe is taken, and that the flag clears they check are not cancelled by a same-cycle set of the same bit. The stimulus drives every input only on the falling edge, so all of these hold. Reset strobes are drawn rarely enough that the full delay count often completes and the monitor enable is reached. Sleep, idle and software writes are drawn often, including in the same cycle as reset strobes, to exercise the priority rules.

// File: rtl/rsc_pkg.sv
`timescale 1ns/1ps
// Package: shared bit positions, event bundle and sequencer states.
// Assumes: flag positions are fixed because software decodes them.
package rsc_pkg;
    localparam int B_POR   = 0;
    localparam int B_BOR   = 1;
    localparam int B_IDLE  = 2;
    localparam int B_SLEEP = 3;
    localparam int B_WDT   = 4;
    localparam int B_SWR   = 6;
    localparam int B_EXT   = 7;
    localparam int B_ILLOP = 14;
    localparam int B_TRAP  = 15;
    localparam logic [15:0] FLAG_MASK = 16'hC0DF;

    typedef struct packed {
        logic por;
        logic bor;
        logic pin;
        logic swrst;
        logic wdt;
        logic trap;
        logic illop;
        logic sleep;
        logic idle;
    } rst_ev_t;

    typedef enum logic [1:0] {SQ_POR, SQ_PWRT, SQ_RUN} seq_st_t;
endpackage

// File: rtl/cause_flags.sv
`timescale 1ns/1ps
// Module: cause_flags - packed reset-cause status word.
// Each implemented bit has its own set and clear events. Priority per bit:
// hardware set, then hardware clear, then software write.
// Assumes: event inputs are one-cycle strobes.
module cause_flags
    import rsc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  rst_ev_t     ev,
    input  logic        sw_wr_en,
    input  logic [15:0] sw_wr_data,
    output logic [15:0] status
);
    logic        pwr_ev;
    logic [15:0] hw_set;
    logic [15:0] hw_clr;
    logic [15:0] wr_bits;

    // Power-on or brown-out, the common clearing condition.
    assign pwr_ev  = ev.por | ev.bor;
    // Software data limited to implemented flags.
    assign wr_bits = sw_wr_data & FLAG_MASK;

    // Build per-bit hardware set vector.
    always_comb begin
        hw_set          = '0;
        hw_set[B_POR]   = ev.por;
        hw_set[B_BOR]   = pwr_ev;
        hw_set[B_IDLE]  = ev.idle;
        hw_set[B_SLEEP] = ev.sleep;
        hw_set[B_WDT]   = ev.wdt;
        hw_set[B_SWR]   = ev.swrst;
        hw_set[B_EXT]   = ev.pin;
        hw_set[B_ILLOP] = ev.illop;
        hw_set[B_TRAP]  = ev.trap;
    end

    // Build per-bit hardware clear vector.
    always_comb begin
        hw_clr          = '0;
        hw_clr[B_IDLE]  = pwr_ev;
        hw_clr[B_SLEEP] = pwr_ev;
        hw_clr[B_WDT]   = pwr_ev | ev.sleep | ev.idle;
        hw_clr[B_SWR]   = pwr_ev;
        hw_clr[B_EXT]   = ev.por;
        hw_clr[B_ILLOP] = pwr_ev;
        hw_clr[B_TRAP]  = pwr_ev;
    end

    for (genvar i = 0; i < 16; i++) begin : g_bit
        if (FLAG_MASK[i]) begin : g_flag
            // One flag register with set > clear > software priority.
            always_ff @(posedge clk) begin
                if (!rst_n)          status[i] <= 1'b0;
                else if (hw_set[i])  status[i] <= 1'b1;
                else if (hw_clr[i])  status[i] <= 1'b0;
                else if (sw_wr_en)   status[i] <= wr_bits[i];
            end
        end else begin : g_zero
            // Unimplemented bit: masked data, always zero.
            assign status[i] = wr_bits[i];
        end
    end
endmodule

// File: rtl/clk_src_pick.sv
`timescale 1ns/1ps
// Module: clk_src_pick - latches the clock-source code at each reset.
// Power-class resets use the configured code. Other resets reuse the
// current code when switching is enabled.
// Assumes: selector inputs are stable at the edge of the reset strobe.
module clk_src_pick #(
    parameter int SELW = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            any_rst,
    input  logic            pwr_rst,
    input  logic            switch_en,
    input  logic [SELW-1:0] cfg_sel,
    input  logic [SELW-1:0] cur_sel,
    output logic [SELW-1:0] sel
);
    // Capture the chosen code on every reset strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sel <= '0;
        else if (any_rst)
            sel <= (switch_en && !pwr_rst) ? cur_sel : cfg_sel;
    end
endmodule

// File: rtl/reset_sequencer.sv
`timescale 1ns/1ps
// Module: reset_sequencer - times system reset release and monitor enable.
// A power-on delay is followed by a power-up timer delay. Any restart
// returns to the start. The monitor enable follows release by MON_DLY.
// Assumes: POR_CYC and PWRT_CYC are at least 1.
module reset_sequencer
    import rsc_pkg::*;
#(
    parameter int POR_CYC  = 16,
    parameter int PWRT_CYC = 64,
    parameter int MON_DLY  = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic osc_ready,
    input  logic pll_locked,
    output logic sys_rst,
    output logic run_enable,
    output logic clkmon_en
);
    localparam int CMAX = (POR_CYC > PWRT_CYC) ? POR_CYC : PWRT_CYC;
    localparam int CW   = $clog2(CMAX + 1);
    localparam int MW   = $clog2(MON_DLY + 2);
    localparam logic [CW-1:0] POR_LAST  = CW'(POR_CYC - 1);
    localparam logic [CW-1:0] PWRT_LAST = CW'(PWRT_CYC - 1);
    localparam logic [MW-1:0] MON_END   = MW'(MON_DLY);

    seq_st_t       st;
    logic [CW-1:0] cnt;
    logic [MW-1:0] mon;

    // Two-phase delay state machine with restart.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            st  <= SQ_POR;
            cnt <= '0;
        end else begin
            case (st)
                SQ_POR: begin
                    if (cnt == POR_LAST) begin
                        st  <= SQ_PWRT;
                        cnt <= '0;
                    end else cnt <= cnt + 1'b1;
                end
                SQ_PWRT: begin
                    if (cnt == PWRT_LAST) begin
                        st  <= SQ_RUN;
                        cnt <= '0;
                    end else cnt <= cnt + 1'b1;
                end
                SQ_RUN:  cnt <= '0;
                default: st  <= SQ_POR;
            endcase
        end
    end

    // Count cycles since release, saturating at MON_DLY.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || st != SQ_RUN) mon <= '0;
        else if (mon != MON_END)               mon <= mon + 1'b1;
    end

    // Output decode.
    assign sys_rst    = (st != SQ_RUN);
    assign run_enable = !sys_rst && osc_ready && pll_locked;
    assign clkmon_en  = (st == SQ_RUN) && (mon == MON_END);
endmodule

// File: rtl/reset_status_ctrl.sv
`timescale 1ns/1ps
// Module: reset_status_ctrl - top of the reset cause and sequencing block.
// Bundles the strobes and feeds the flag register, clock-source picker
// and release sequencer.
// Assumes: all event inputs are synchronous one-cycle strobes.
module reset_status_ctrl
    import rsc_pkg::*;
#(
    parameter int POR_CYC  = 16,
    parameter int PWRT_CYC = 64,
    parameter int MON_DLY  = 8,
    parameter int SELW     = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ev_por,
    input  logic            ev_bor,
    input  logic            ev_pin,
    input  logic            ev_swrst,
    input  logic            ev_wdt,
    input  logic            ev_trap,
    input  logic            ev_illop,
    input  logic            ev_sleep,
    input  logic            ev_idle,
    input  logic            sw_wr_en,
    input  logic [15:0]     sw_wr_data,
    input  logic            clk_switch_en,
    input  logic [SELW-1:0] cfg_osc_sel,
    input  logic [SELW-1:0] cur_osc_sel,
    input  logic            osc_ready,
    input  logic            pll_locked,
    output logic [15:0]     status,
    output logic [SELW-1:0] clk_src_sel,
    output logic            sys_rst,
    output logic            run_enable,
    output logic            clkmon_en
);
    rst_ev_t ev;
    logic    pwr_rst;
    logic    any_rst;

    // Pack strobes and classify reset kinds.
    always_comb begin
        ev       = '{por: ev_por, bor: ev_bor, pin: ev_pin, swrst: ev_swrst,
                     wdt: ev_wdt, trap: ev_trap, illop: ev_illop,
                     sleep: ev_sleep, idle: ev_idle};
        pwr_rst  = ev_por | ev_bor;
        any_rst  = pwr_rst | ev_pin | ev_swrst | ev_wdt | ev_trap | ev_illop;
    end

    cause_flags u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .ev         (ev),
        .sw_wr_en   (sw_wr_en),
        .sw_wr_data (sw_wr_data),
        .status     (status)
    );

    clk_src_pick #(.SELW(SELW)) u_pick (
        .clk       (clk),
        .rst_n     (rst_n),
        .any_rst   (any_rst),
        .pwr_rst   (pwr_rst),
        .switch_en (clk_switch_en),
        .cfg_sel   (cfg_osc_sel),
        .cur_sel   (cur_osc_sel),
        .sel       (clk_src_sel)
    );

    reset_sequencer #(
        .POR_CYC  (POR_CYC),
        .PWRT_CYC (PWRT_CYC),
        .MON_DLY  (MON_DLY)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (any_rst),
        .osc_ready  (osc_ready),
        .pll_locked (pll_locked),
        .sys_rst    (sys_rst),
        .run_enable (run_enable),
        .clkmon_en  (clkmon_en)
    );
endmodule

// File: rtl/reset_status_ctrl_chk.sv
`timescale 1ns/1ps
// Module: reset_status_ctrl_chk - temporal properties on the top's ports.
// Assumes: strobes change only between clock edges.
module reset_status_ctrl_chk #(
    parameter int SELW = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            ev_por,
    input logic            ev_bor,
    input logic            ev_pin,
    input logic            ev_swrst,
    input logic            ev_wdt,
    input logic            ev_trap,
    input logic            ev_illop,
    input logic            ev_sleep,
    input logic            ev_idle,
    input logic            sw_wr_en,
    input logic [15:0]     sw_wr_data,
    input logic            clk_switch_en,
    input logic [SELW-1:0] cfg_osc_sel,
    input logic [15:0]     status,
    input logic [SELW-1:0] clk_src_sel,
    input logic            sys_rst,
    input logic            clkmon_en
);
    logic any_rst;
    // Any reset-class strobe seen at the ports.
    assign any_rst = ev_por | ev_bor | ev_pin | ev_swrst | ev_wdt | ev_trap | ev_illop;

    AST_UNUSED_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (status & 16'h3F20) == 16'h0000); // R1
    AST_POR_SETS_TWO: assert property (@(posedge clk) disable iff (!rst_n)
        ev_por |=> (status[0] && status[1])); // R2
    AST_BOR_CLEARS_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_bor && !ev_trap) |=> !status[15]); // R3
    AST_PSAVE_CLEARS_WDT: assert property (@(posedge clk) disable iff (!rst_n)
        ((ev_sleep || ev_idle) && !ev_wdt) |=> !status[4]); // R4
    AST_SW_LOSES_TO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_wr_en && !sw_wr_data[0] && ev_por) |=> status[0]); // R5
    AST_FIXED_SRC_CFG: assert property (@(posedge clk) disable iff (!rst_n)
        (any_rst && !clk_switch_en) |=> (clk_src_sel == $past(cfg_osc_sel))); // R7
    AST_RESET_ASSERTS: assert property (@(posedge clk) disable iff (!rst_n)
        any_rst |=> sys_rst); // R8
    AST_MON_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        clkmon_en |-> !sys_rst); // R10
endmodule

bind reset_status_ctrl reset_status_ctrl_chk #(.SELW(SELW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ev_por        (ev_por),
    .ev_bor        (ev_bor),
    .ev_pin        (ev_pin),
    .ev_swrst      (ev_swrst),
    .ev_wdt        (ev_wdt),
    .ev_trap       (ev_trap),
    .ev_illop      (ev_illop),
    .ev_sleep      (ev_sleep),
    .ev_idle       (ev_idle),
    .sw_wr_en      (sw_wr_en),
    .sw_wr_data    (sw_wr_data),
    .clk_switch_en (clk_switch_en),
    .cfg_osc_sel   (cfg_osc_sel),
    .status        (status),
    .clk_src_sel   (clk_src_sel),
    .sys_rst       (sys_rst),
    .clkmon_en     (clkmon_en)
);

// File: tb/reset_status_ctrl_bench.sv
`timescale 1ns/1ps
// Bench: directed corners plus seeded random strobes, compared each cycle
// with a bench-side model built from the requirements.
module reset_status_ctrl_bench;
    localparam int POR_CYC  = 16;
    localparam int PWRT_CYC = 64;
    localparam int MON_DLY  = 8;
    localparam int SEQ_LEN  = POR_CYC + PWRT_CYC;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ev_por = 0, ev_bor = 0, ev_pin = 0, ev_swrst = 0, ev_wdt = 0;
    logic ev_trap = 0, ev_illop = 0, ev_sleep = 0, ev_idle = 0;
    logic sw_wr_en = 0;
    logic [15:0] sw_wr_data = '0;
    logic clk_switch_en = 0;
    logic [2:0] cfg_osc_sel = '0, cur_osc_sel = '0;
    logic osc_ready = 0, pll_locked = 0;
    logic [15:0] status;
    logic [2:0]  clk_src_sel;
    logic sys_rst, run_enable, clkmon_en;

    int checks = 0;
    int fails  = 0;

    logic [15:0] m_status;
    logic [2:0]  m_sel;
    int          m_rem;
    int          m_mon;

    always #10 clk = ~clk;

    reset_status_ctrl #(.POR_CYC(POR_CYC), .PWRT_CYC(PWRT_CYC), .MON_DLY(MON_DLY))
    u_reset_status_ctrl (
        .clk(clk), .rst_n(rst_n), .ev_por(ev_por), .ev_bor(ev_bor), .ev_pin(ev_pin),
        .ev_swrst(ev_swrst), .ev_wdt(ev_wdt), .ev_trap(ev_trap), .ev_illop(ev_illop),
        .ev_sleep(ev_sleep), .ev_idle(ev_idle), .sw_wr_en(sw_wr_en),
        .sw_wr_data(sw_wr_data), .clk_switch_en(clk_switch_en),
        .cfg_osc_sel(cfg_osc_sel), .cur_osc_sel(cur_osc_sel), .osc_ready(osc_ready),
        .pll_locked(pll_locked), .status(status), .clk_src_sel(clk_src_sel),
        .sys_rst(sys_rst), .run_enable(run_enable), .clkmon_en(clkmon_en)
    );

    // Expected next status word from the flag rules (R1..R5).
    function automatic logic [15:0] next_flags(input logic [15:0] s);
        logic [15:0] r;
        logic pb;
        pb = ev_por | ev_bor;
        r = sw_wr_en ? (sw_wr_data & 16'hC0DF) : s;
        if (pb) begin
            r[15] = 0; r[14] = 0; r[6] = 0; r[3] = 0; r[2] = 0;
        end
        if (ev_por) r[7] = 0;
        if (pb || ev_sleep || ev_idle) r[4] = 0;
        if (ev_por) begin r[0] = 1; r[1] = 1; end
        if (ev_bor)   r[1]  = 1;
        if (ev_pin)   r[7]  = 1;
        if (ev_swrst) r[6]  = 1;
        if (ev_wdt)   r[4]  = 1;
        if (ev_trap)  r[15] = 1;
        if (ev_illop) r[14] = 1;
        if (ev_sleep) r[3]  = 1;
        if (ev_idle)  r[2]  = 1;
        return r;
    endfunction

    function automatic logic any_reset();
        return ev_por | ev_bor | ev_pin | ev_swrst | ev_wdt | ev_trap | ev_illop;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    // One clock: update the model at the edge, compare at the falling edge.
    task automatic cycle();
        @(posedge clk);
        if (!rst_n) begin
            m_status = '0; m_sel = '0; m_rem = SEQ_LEN; m_mon = 0;
        end else begin
            m_status = next_flags(m_status);
            if (any_reset())
                m_sel = (clk_switch_en && !(ev_por || ev_bor)) ? cur_osc_sel : cfg_osc_sel;
            if (any_reset())     begin m_rem = SEQ_LEN; m_mon = 0; end
            else if (m_rem > 0)  begin m_rem--;         m_mon = 0; end
            else if (m_mon < MON_DLY) m_mon++;
        end
        @(negedge clk);
        check("R3 status", 32'(status), 32'(m_status));
        check("R6 clk_src_sel", 32'(clk_src_sel), 32'(m_sel));
        check("R8 sys_rst", 32'(sys_rst), 32'(m_rem > 0));
        check("R9 run_enable", 32'(run_enable), 32'((m_rem == 0) && osc_ready && pll_locked));
        check("R10 clkmon_en", 32'(clkmon_en), 32'(m_mon == MON_DLY));
    endtask

    task automatic quiet();
        {ev_por, ev_bor, ev_pin, ev_swrst, ev_wdt, ev_trap, ev_illop, ev_sleep, ev_idle} = '0;
        sw_wr_en = 0;
    endtask

    task automatic idle_cycles(input int n);
        quiet();
        for (int i = 0; i < n; i++) cycle();
    endtask

    // Watchdog: a hung run is a failure but still prints the summary.
    initial begin
        #(200000 * 20);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        for (int i = 0; i < 3; i++) cycle();
        // R11 reset state
        check("R11 status", 32'(status), 32'h0);
        check("R11 clk_src_sel", 32'(clk_src_sel), 32'h0);
        check("R11 sys_rst", 32'(sys_rst), 32'h1);
        check("R11 clkmon_en", 32'(clkmon_en), 32'h0);
        rst_n = 1;
        osc_ready = 1; pll_locked = 1;
        cfg_osc_sel = 3'd2; cur_osc_sel = 3'd5;

        // R2 power-on sets bits 0 and 1
        ev_por = 1; cycle(); quiet();
        check("R2 por", 32'(status), 32'h0003);
        idle_cycles(SEQ_LEN + MON_DLY + 2);
        check("R10 monitor up", 32'(clkmon_en), 32'h1);
        check("R9 run", 32'(run_enable), 32'h1);

        // R3 trap cleared by brown-out, pin flag kept, later cleared by power-on
        ev_trap = 1; ev_pin = 1; cycle(); quiet();
        check("R3 trap+pin set", 32'(status & 16'h8080), 32'h8080);
        ev_bor = 1; cycle(); quiet();
        check("R3 bor keeps pin", 32'(status & 16'h8080), 32'h0080);
        ev_por = 1; cycle(); quiet();
        check("R3 por clears pin", 32'(status), 32'h0003);

        // R4 sleep clears watchdog and sets its own flag
        ev_wdt = 1; cycle(); quiet();
        ev_sleep = 1; cycle(); quiet();
        check("R4 sleep", 32'(status & 16'h001C), 32'h0008);
        ev_wdt = 1; cycle(); quiet();
        ev_idle = 1; cycle(); quiet();
        check("R4 idle", 32'(status & 16'h001C), 32'h000C);

        // R1 unused bits read zero
        sw_wr_en = 1; sw_wr_data = 16'hFFFF; cycle(); quiet();
        check("R1 mask", 32'(status), 32'hC0DF);
        // R5 set beats software write of zero
        sw_wr_en = 1; sw_wr_data = 16'h0000; ev_por = 1; ev_trap = 1; cycle(); quiet();
        check("R5 priority", 32'(status), 32'h8003);

        // R6 switching enabled: pin uses current, brown-out uses config
        clk_switch_en = 1;
        ev_pin = 1; cycle(); quiet();
        check("R6 pin cur", 32'(clk_src_sel), 32'd5);
        ev_bor = 1; ev_wdt = 1; cycle(); quiet();
        check("R6 bor cfg", 32'(clk_src_sel), 32'd2);
        // R7 switching disabled: watchdog uses config
        clk_switch_en = 0; cfg_osc_sel = 3'd6;
        ev_wdt = 1; cycle(); quiet();
        check("R7 fixed", 32'(clk_src_sel), 32'd6);

        // R8 restart mid-count extends reset
        idle_cycles(40);
        ev_swrst = 1; cycle(); quiet();
        idle_cycles(SEQ_LEN - 1);
        check("R8 still held", 32'(sys_rst), 32'h1);
        idle_cycles(1);
        check("R8 released", 32'(sys_rst), 32'h0);

        // Random mix
        for (int n = 0; n < 6000; n++) begin
            ev_por   = ($urandom % 3000) == 0;
            ev_bor   = ($urandom % 2000) == 0;
            ev_pin   = ($urandom % 2000) == 0;
            ev_swrst = ($urandom % 2000) == 0;
            ev_wdt   = ($urandom % 2000) == 0;
            ev_trap  = ($urandom % 2000) == 0;
            ev_illop = ($urandom % 2000) == 0;
            ev_sleep = ($urandom % 30) == 0;
            ev_idle  = ($urandom % 30) == 0;
            sw_wr_en = ($urandom % 20) == 0;
            sw_wr_data = 16'($urandom);
            if (($urandom % 100) == 0) clk_switch_en = ~clk_switch_en;
            cfg_osc_sel = 3'($urandom);
            cur_osc_sel = 3'($urandom);
            osc_ready  = ($urandom % 8) != 0;
            pll_locked = ($urandom % 8) != 0;
            cycle();
        end
        quiet();

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule